// File: doc/BRIEF.md
# Edge-to-Pulse Encoder with Refresh

This block is the transmit side of one isolated logic channel. It takes a single asynchronous logic input and brings it into the local clock domain through a two-flop synchroniser. A counting glitch filter follows, so only levels that hold for a minimum number of clocks are accepted. Each accepted rising edge becomes a one-clock pulse on the set line. Each accepted falling edge becomes a one-clock pulse on the clear line. A downstream coupler turns these two strobes into barrier pulses.

A DC level has no edges, so the far side could lose track of it. To prevent this, the encoder keeps an idle counter. When no edge has been accepted for `IDLE_CYC` clocks, it emits a refresh pulse on the line that matches the present filtered level. While the input stays idle, it repeats that pulse every `REFRESH_CYC` clocks. With the default 100 MHz clock these give roughly 1 µs of idle time and about 1.18 M refreshes per second.

Right after reset, one refresh pulse is sent at once, so the receiver learns the level without waiting. The enable input silences the block completely and holds the idle counter cleared.

Top module: `edge_pulse_enc`

## Requirements
- R1: A rising input level that holds for at least `FILT_CYC` clocks produces exactly one set pulse. With the defaults it is visible after the 6th rising clock edge following the input change (2 synchroniser stages plus `FILT_CYC`=4).
- R2: A falling input level that holds for at least `FILT_CYC` clocks produces exactly one clear pulse, with the same latency as R1.
- R3: An input pulse narrower than `FILT_CYC` clocks produces no set or clear pulse. It also does not restart the idle counter.
- R4: An input pulse exactly `FILT_CYC` clocks wide passes. It gives a set pulse and, `FILT_CYC` clocks later, a clear pulse.
- R5: The set and clear outputs are never high in the same cycle, and each pulse lasts exactly one clock.
- R6: After an accepted edge pulse, if the input stays idle, a refresh pulse follows exactly `IDLE_CYC` clocks later. It appears on set when the filtered level is 1 and on clear when it is 0.
- R7: While the input stays idle, each further refresh pulse follows the previous one by exactly `REFRESH_CYC` clocks, on the line of the current level.
- R8: Both outputs are low during reset. On the first clock edge after reset is released, a refresh pulse of the filtered level appears (clear, since that level starts at 0), and the next refresh follows `REFRESH_CYC` clocks later.
- R9: While enable is low, no pulse is emitted and edges accepted in that time are dropped. Once enable returns high, the first refresh pulse appears on the `IDLE_CYC`-th rising edge at which enable is sampled high.
- R10: Every accepted edge restarts the idle interval, so the next refresh is measured from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low silences outputs and clears the idle counter |
| din_i | input | 1 | Asynchronous logic input |
| set_o | output | 1 | One-clock strobe: rising edge or refresh of level 1 |
| clr_o | output | 1 | One-clock strobe: falling edge or refresh of level 0 |

## Verification
On every cycle, the embedded assertions check the following:
- set and clear stay mutually exclusive and one clock wide;
- each set pulse agrees with filtered level 1 and each clear pulse with level 0;
- the filtered level only moves to a value the synchronised input already held;
- a low enable leaves both outputs quiet and the idle counter at zero.

Some behaviour can only be shown by the bench's directed scenarios:
- the exact latency of an edge pulse;
- the rejection of a pulse one clock short of the filter window, and the acceptance of one exactly at the window;
- the idle and repeat spacing of refresh pulses;
- the immediate refresh after reset;
- the timing of the first refresh after re-enable.

// File: rtl/edge_enc_pkg.sv
package edge_enc_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } pulse_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eenc_sync.sv
module eenc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b0;
        else if (g == 0) sr_q[g] <= d_i;
        else sr_q[g] <= sr_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/eenc_filter.sv
module eenc_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic acc_o   // level flips at the next edge
);

  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          diff;

  assign diff  = d_i ^ lvl_q;
  assign acc_o = diff && (cnt_q == CW'(FILT_CYC - 1));
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (acc_o) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else if (diff) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> (lvl_q == $past(d_i))) else $error("filter jump"); // R3
  AST_FILT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(FILT_CYC)) else $error("filter count"); // R4

endmodule

// File: rtl/eenc_timer.sv
module eenc_timer
  import edge_enc_pkg::*;
#(
  parameter int unsigned IDLE_CYC    = 100,
  parameter int unsigned REFRESH_CYC = 85
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic acc_i,
  output logic ref_o
);

  localparam int unsigned TMAX = max2(IDLE_CYC, REFRESH_CYC);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q;
  logic          rep_q;   // last event was a refresh
  logic          pend_q;  // startup refresh owed
  logic [CW-1:0] thr;

  assign thr   = rep_q ? CW'(REFRESH_CYC - 1) : CW'(IDLE_CYC - 1);
  assign ref_o = en_i && !acc_i && (pend_q || (cnt_q == thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rep_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      rep_q  <= 1'b0;
    end else if (acc_i) begin
      cnt_q  <= '0;
      rep_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (ref_o) begin
      cnt_q  <= '0;
      rep_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_HELD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)) else $error("idle counter not held"); // R9
  AST_IDLE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TMAX)) else $error("idle counter overrun"); // R7

endmodule

// File: rtl/edge_pulse_enc.sv
module edge_pulse_enc
  import edge_enc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned IDLE_CYC    = 100,
  parameter int unsigned REFRESH_CYC = 85
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic din_i,
  output logic set_o,
  output logic clr_o
);

  logic   din_s;
  logic   lvl;
  logic   acc;
  logic   refr;
  pulse_t pls_d, pls_q;

  eenc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(din_i), .q_o(din_s)
  );

  eenc_filter #(.FILT_CYC(FILT_CYC)) i_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(din_s), .lvl_o(lvl), .acc_o(acc)
  );

  eenc_timer #(.IDLE_CYC(IDLE_CYC), .REFRESH_CYC(REFRESH_CYC)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .acc_i(acc), .ref_o(refr)
  );

  // edge carries the new level (~lvl); refresh carries the current one
  always_comb begin
    pls_d.set = en_i && ((acc && !lvl) || (refr && lvl));
    pls_d.clr = en_i && ((acc && lvl) || (refr && !lvl));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pls_q <= '0;
    else         pls_q <= pls_d;
  end

  assign set_o = pls_q.set;
  assign clr_o = pls_q.clr;

  AST_SET_CLR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_o && clr_o)) else $error("set and clr together"); // R5
  AST_SET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o) else $error("set wider than one clock"); // R5
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o) else $error("clr wider than one clock"); // R5
  AST_SET_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> lvl) else $error("set against level"); // R6
  AST_CLR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> !lvl) else $error("clr against level"); // R6
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(set_o || clr_o)) else $error("pulse while disabled"); // R9

endmodule

// File: tb/test_edge_pulse_enc.sv
`timescale 1ns/1ps
module test_edge_pulse_enc;

  localparam int FILT = 4;
  localparam int IDLE = 100;
  localparam int REFR = 85;
  localparam int LAT  = 2 + FILT;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1;
  logic din = 1'b0;
  logic set_o, clr_o;

  int n_chk = 0;
  int n_err = 0;
  int both_cnt = 0;
  int wide_cnt = 0;
  int ns, nr;
  int sidx [4];
  int ridx [4];

  always #5 clk = ~clk;

  edge_pulse_enc i_edge_pulse_enc (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .din_i(din),
    .set_o(set_o), .clr_o(clr_o)
  );

  // R5 monitor
  logic set_p = 1'b0, clr_p = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (set_o && clr_o) both_cnt++;
      if ((set_o && set_p) || (clr_o && clr_p)) wide_cnt++;
    end
    set_p = set_o;
    clr_p = clr_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive din=v now; if w>0 return to ~v after w cycles; record pulses for n cycles
  task automatic run(input int n, input int w, input logic v);
    ns = 0; nr = 0;
    for (int k = 0; k < 4; k++) begin sidx[k] = -1; ridx[k] = -1; end
    din = v;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (set_o) begin if (ns < 4) sidx[ns] = i; ns++; end
      if (clr_o) begin if (nr < 4) ridx[nr] = i; nr++; end
      if (w > 0 && i == w) din = ~v;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!set_o && !clr_o, "R8 reset state", {set_o, clr_o}, 0);
    rst_ni = 1'b1;
    run(1 + REFR, 0, 1'b0);
    check(nr == 2 && ns == 0, "R8 pulse count", nr, 2);
    check(ridx[0] == 1, "R8 startup refresh cycle", ridx[0], 1);
    check(ridx[1] == 1 + REFR, "R7 repeat after startup", ridx[1], 1 + REFR);
  endtask

  task automatic t_rise;
    run(LAT + IDLE, 0, 1'b1);
    check(ns == 2 && nr == 0, "R1 set count", ns, 2);
    check(sidx[0] == LAT, "R1 set latency", sidx[0], LAT);
    check(sidx[1] == LAT + IDLE, "R6 R10 refresh after rise", sidx[1], LAT + IDLE);
  endtask

  task automatic t_fall;
    run(LAT + IDLE, 0, 1'b0);
    check(nr == 2 && ns == 0, "R2 clr count", nr, 2);
    check(ridx[0] == LAT, "R2 clr latency", ridx[0], LAT);
    check(ridx[1] == LAT + IDLE, "R6 refresh on clr line", ridx[1], LAT + IDLE);
  endtask

  task automatic t_glitch;
    run(REFR, FILT - 1, 1'b1);
    check(ns == 0, "R3 glitch gives no set", ns, 0);
    check(nr == 1 && ridx[0] == REFR, "R3 idle not restarted", ridx[0], REFR);
  endtask

  task automatic t_min_pulse;
    run(LAT + FILT + IDLE, FILT, 1'b1);
    check(ns == 1 && sidx[0] == LAT, "R4 set of min pulse", sidx[0], LAT);
    check(nr == 2 && ridx[0] == LAT + FILT, "R4 clr of min pulse", ridx[0], LAT + FILT);
    check(ridx[1] == LAT + FILT + IDLE, "R10 refresh after last edge", ridx[1], LAT + FILT + IDLE);
  endtask

  task automatic t_enable;
    en = 1'b0;
    run(3 * IDLE, 0, 1'b1);
    check(ns == 0 && nr == 0, "R9 quiet while disabled", ns + nr, 0);
    en = 1'b1;
    run(IDLE, 0, 1'b1);
    check(ns == 1 && nr == 0, "R9 one refresh after enable", ns, 1);
    check(sidx[0] == IDLE, "R9 refresh timing after enable", sidx[0], IDLE);
  endtask

  task automatic t_idle_train;
    run(3 * REFR, 0, 1'b1);
    check(ns == 3 && nr == 0, "R7 refresh count", ns, 3);
    check(sidx[0] == REFR && sidx[2] == 3 * REFR, "R7 refresh spacing", sidx[2], 3 * REFR);
  endtask

  initial begin
    #200000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_glitch();
    t_min_pulse();
    t_enable();
    t_idle_train();
    check(both_cnt == 0, "R5 set and clr overlap", both_cnt, 0);
    check(wide_cnt == 0, "R5 pulse width", wide_cnt, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule